// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Byte Bypass

This block is a synchronous single-port memory for simulation and FPGA builds. A command (select, write enable, byte-write enables and address) is registered on a rising clock edge. Read data comes from an output register, one edge after the command edge. Write data follows its command by one cycle. It is then parked in a write buffer, which reaches the storage array only when a later write arrives. Any number of reads may come between the two writes.

Each read address is compared with the parked write address. When they match, the word is assembled byte by byte: bytes enabled in the parked write come from the buffer, and all other bytes come from the array. The data word has four 9-bit bytes. An output-enable input and a sleep input force the data outputs off. In this model, off is a low `dout_oe` flag rather than a tri-stated pin. Sleep also turns commands into no-operations. The array contents are not reset and stay undefined until written.

Top module: `latewrite_sram`

## Requirements
- R1: `addr`, `sel_n`, `we_n` and `be_n` are sampled only on the rising edge of `clk`. A command is a read when `sel_n`=0 and `we_n`=1, and a write when `sel_n`=0 and `we_n`=0.
- R2: A read sampled at edge N has its data on `dout`, with `dout_oe` high, from edge N+1 until edge N+2.
- R3: The data of a write sampled at edge N is taken from `din` at edge N+1.
- R4: A write is held in a buffer and reaches the array only when the next write is taken. Reads that come in between return the buffered value for the buffered address.
- R5: When a read address equals the buffered write address, each byte enabled in that write comes from the buffer and each other byte comes from the array.
- R6: The word is four 9-bit bytes. Byte i occupies bits 9i+8..9i, and `be_n[i]`=0 enables writing byte i.
- R7: `sel_n`=1 at an edge makes that cycle a no-operation. `oe_n`=1 forces `dout_oe` low at once, and `oe_n`=0 restores it while read data is held.
- R8: `sleep`=1 forces `dout_oe` low and turns commands into no-operations. Stored contents are kept.
- R9: Reads of the same address at consecutive edges leave `dout` unchanged between them.
- R10: A write with all of `be_n` high changes no byte.
- R11: `dout_oe` is low in every cycle that does not follow a read edge, including after reset.
- R12: The buffer-valid flag is cleared by reset. Until a write's data is taken again, reads come only from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address of the command |
| sel_n | input | 1 | Active-low command select |
| we_n | input | 1 | Active-low write enable (high means read) |
| be_n | input | NBYTES | Active-low byte-write enables |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Low-power request: outputs off, no operations |
| din | input | NBYTES*BYTE_W | Write data, one cycle after its command |
| dout | output | NBYTES*BYTE_W | Read data from the output register |
| dout_oe | output | 1 | High while `dout` is being driven |

## Verification
On every cycle, the embedded properties check four things:
- Idle and sleeping commands decode to no-operations.
- The buffer changes only in a write-data cycle.
- Each byte of a merged read word comes from the correct source.
- `dout_oe` is high only two edges after a read was sampled, and same-address consecutive reads keep the output register steady.

Only the bench's scenarios can show the following:
- A buffered write reaches the array exactly when the next write arrives.
- Partial and empty byte masks leave the right bytes untouched.
- Back-to-back writes commit correctly.
- Data survives sleep.
- Reset makes a pending buffer invisible.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Command decode from the sampled control pins.
  function automatic op_e decode_op(input logic sel_n, input logic we_n, input logic sleep);
    if (sleep || sel_n) return OP_IDLE;
    return we_n ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/lwsram_cmd_stage.sv
`timescale 1ns/1ps
module lwsram_cmd_stage
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [NBYTES-1:0] be_n,
  input  logic              sleep,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NBYTES-1:0] mask_q
);
  op_e cmd_now;
  assign cmd_now = decode_op(sel_n, we_n, sleep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      op_q <= cmd_now;
      if (cmd_now != OP_IDLE) begin
        addr_q <= addr;
        mask_q <= ~be_n;
      end
    end
  end

  // R7 R8
  nop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || sel_n) |=> (op_q == OP_IDLE));

  // R1
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && we_n) |=> (op_q == OP_READ && addr_q == $past(addr)));
endmodule

// File: rtl/lwsram_wbuf.sv
`timescale 1ns/1ps
module lwsram_wbuf #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_phase,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [NBYTES-1:0] mask_q,
  input  logic [WORD_W-1:0] din,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [NBYTES-1:0] buf_mask,
  output logic [WORD_W-1:0] buf_data,
  output logic              commit_fire
);
  // The previous buffered write leaves for the array as the next one lands.
  assign commit_fire = data_phase && buf_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) buf_valid <= 1'b0;
    else if (data_phase) buf_valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (data_phase) begin
      buf_addr <= addr_q;
      buf_mask <= mask_q;
      buf_data <= din;
    end
  end

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !data_phase) |=> ($stable(buf_addr) && $stable(buf_mask) && $stable(buf_data)));

  // R12
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> $past(data_phase));
endmodule

// File: rtl/lwsram_array.sv
`timescale 1ns/1ps
module lwsram_array #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int WORD_W = BYTE_W * NBYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) bank[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end
    assign rd_data[b*BYTE_W +: BYTE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/lwsram_bypass.sv
`timescale 1ns/1ps
module lwsram_bypass #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              buf_valid,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [NBYTES-1:0] buf_mask,
  input  logic [WORD_W-1:0] buf_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] arr_data,
  output logic              bypass_hit,
  output logic [WORD_W-1:0] merged
);
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] newer, input logic [WORD_W-1:0] older,
    input logic [NBYTES-1:0] pick);
    logic [WORD_W-1:0] w;
    for (int b = 0; b < NBYTES; b++)
      w[b*BYTE_W +: BYTE_W] = pick[b] ? newer[b*BYTE_W +: BYTE_W] : older[b*BYTE_W +: BYTE_W];
    return w;
  endfunction

  logic [NBYTES-1:0] use_buf;
  assign bypass_hit = buf_valid && (buf_addr == rd_addr);
  assign use_buf    = bypass_hit ? buf_mask : '0;
  assign merged     = merge_word(buf_data, arr_data, use_buf);

  // R5 R6 R10
  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      if (bypass_hit && buf_mask[b]) begin
        byte_from_buf_chk: assert (merged[b*BYTE_W +: BYTE_W] == buf_data[b*BYTE_W +: BYTE_W]);
      end else begin
        byte_from_arr_chk: assert (merged[b*BYTE_W +: BYTE_W] == arr_data[b*BYTE_W +: BYTE_W]);
      end
    end
  end
endmodule

// File: rtl/latewrite_sram.sv
`timescale 1ns/1ps
module latewrite_sram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [NBYTES-1:0] be_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NBYTES-1:0] mask_q;
  logic              data_phase;
  logic              buf_valid;
  logic [ADDR_W-1:0] buf_addr;
  logic [NBYTES-1:0] buf_mask;
  logic [WORD_W-1:0] buf_data;
  logic              commit_fire;
  logic [WORD_W-1:0] arr_data;
  logic              bypass_hit;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] q_reg;
  logic              rd_done;

  lwsram_cmd_stage #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .sleep(sleep), .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q));

  assign data_phase = (op_q == OP_WRITE);

  lwsram_wbuf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .data_phase(data_phase), .addr_q(addr_q),
    .mask_q(mask_q), .din(din), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_mask(buf_mask), .buf_data(buf_data), .commit_fire(commit_fire));

  lwsram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
    .clk(clk), .wr_en(commit_fire), .wr_addr(buf_addr), .wr_mask(buf_mask),
    .wr_data(buf_data), .rd_addr(addr_q), .rd_data(arr_data));

  lwsram_bypass #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_bypass (
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_mask(buf_mask),
    .buf_data(buf_data), .rd_addr(addr_q), .arr_data(arr_data),
    .bypass_hit(bypass_hit), .merged(merged));

  always_ff @(posedge clk) begin
    if (!rst_n) rd_done <= 1'b0;
    else        rd_done <= (op_q == OP_READ);
  end

  always_ff @(posedge clk) begin
    if (op_q == OP_READ) q_reg <= merged;
  end

  assign dout    = q_reg;
  assign dout_oe = rd_done && !oe_n && !sleep;

  // R9
  same_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ && $past(op_q) == OP_READ && addr_q == $past(addr_q)) |=> $stable(q_reg));

  // R11
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!sel_n && we_n && !sleep, 2));
endmodule

// File: tb/latewrite_sram_test.sv
`timescale 1ns/1ps
module latewrite_sram_test;
  localparam real CLK_NS = 4.0;
  localparam int  NROW   = 16;

  typedef struct packed {
    logic [1:0]  kind;   // 0 nop, 1 read, 2 write
    logic [9:0]  a;
    logic [3:0]  ben;
    logic [35:0] d;      // write data, or expected read data
  } row_t;

  localparam row_t TBL [NROW] = '{
    '{2'd2, 10'd9, 4'b0000, {9'h1A1, 9'h1B2, 9'h1C3, 9'h1D4}},
    '{2'd2, 10'd5, 4'b0000, {9'h011, 9'h022, 9'h033, 9'h044}},
    '{2'd1, 10'd5, 4'b1111, {9'h011, 9'h022, 9'h033, 9'h044}},
    '{2'd1, 10'd5, 4'b1111, {9'h011, 9'h022, 9'h033, 9'h044}},
    '{2'd1, 10'd9, 4'b1111, {9'h1A1, 9'h1B2, 9'h1C3, 9'h1D4}},
    '{2'd2, 10'd9, 4'b1010, {9'h0FF, 9'h0EE, 9'h0DD, 9'h0CC}},
    '{2'd1, 10'd9, 4'b1111, {9'h1A1, 9'h0EE, 9'h1C3, 9'h0CC}},
    '{2'd0, 10'd9, 4'b1111, 36'h0},
    '{2'd1, 10'd5, 4'b1111, {9'h011, 9'h022, 9'h033, 9'h044}},
    '{2'd2, 10'd9, 4'b1111, {9'h155, 9'h155, 9'h155, 9'h155}},
    '{2'd1, 10'd9, 4'b1111, {9'h1A1, 9'h0EE, 9'h1C3, 9'h0CC}},
    '{2'd2, 10'd5, 4'b0111, {9'h100, 9'h000, 9'h000, 9'h000}},
    '{2'd2, 10'd5, 4'b1110, {9'h000, 9'h000, 9'h000, 9'h1FF}},
    '{2'd1, 10'd5, 4'b1111, {9'h100, 9'h022, 9'h033, 9'h1FF}},
    '{2'd1, 10'd9, 4'b1111, {9'h1A1, 9'h0EE, 9'h1C3, 9'h0CC}},
    '{2'd0, 10'd0, 4'b1111, 36'h0}
  };

  localparam logic [35:0] A5_MERGED = {9'h100, 9'h022, 9'h033, 9'h1FF};
  localparam logic [35:0] A5_ARRAY  = {9'h100, 9'h022, 9'h033, 9'h044};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  addr;
  logic        sel_n, we_n, oe_n, sleep;
  logic [3:0]  be_n;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_oe;
  int          n_cmp = 0;
  int          n_bad = 0;

  latewrite_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout),
    .dout_oe(dout_oe));

  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drv(input int kind, input logic [9:0] a, input logic [3:0] ben);
    sel_n = (kind == 0);
    we_n  = (kind != 2);
    addr  = a;
    be_n  = ben;
  endtask

  task automatic check_row(input int j);
    if (TBL[j].kind == 2'd1) begin
      chk($sformatf("R2 R11 row %0d oe", j), {35'd0, dout_oe}, 36'd1);
      chk($sformatf("R1 R3 R4 R5 R6 R9 R10 row %0d data", j), dout, TBL[j].d);
    end else begin
      chk($sformatf("R7 R11 row %0d oe off", j), {35'd0, dout_oe}, 36'd0);
    end
  endtask

  initial begin
    #(CLK_NS * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; din = '0;
    drv(0, 10'd0, 4'b1111);
    repeat (3) @(negedge clk);
    chk("R11 reset oe", {35'd0, dout_oe}, 36'd0);
    rst_n = 1'b1;

    // Vector table walk
    for (int i = 0; i < NROW + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_row(i - 2);
      if (i < NROW) drv(TBL[i].kind, TBL[i].a, TBL[i].ben);
      else          drv(0, 10'd0, 4'b1111);
      din = (i >= 1 && i - 1 < NROW && TBL[i-1].kind == 2'd2) ? TBL[i-1].d : '0;
    end

    // R7: output enable gating while read data is held
    drv(1, 10'd5, 4'b1111);
    @(negedge clk); drv(0, 10'd0, 4'b1111); oe_n = 1'b1;
    @(negedge clk);
    chk("R7 oe_n high", {35'd0, dout_oe}, 36'd0);
    oe_n = 1'b0;
    #1;
    chk("R7 oe_n low", {35'd0, dout_oe}, 36'd1);
    chk("R7 held data", dout, A5_MERGED);

    // R8: sleep ignores commands and keeps contents
    drv(2, 10'd5, 4'b0000); sleep = 1'b1;
    @(negedge clk); din = '1; drv(1, 10'd5, 4'b1111);
    @(negedge clk);
    chk("R8 sleep oe", {35'd0, dout_oe}, 36'd0);
    sleep = 1'b0; din = '0; drv(1, 10'd5, 4'b1111);
    @(negedge clk); drv(0, 10'd0, 4'b1111);
    @(negedge clk);
    chk("R8 retained data", dout, A5_MERGED);
    chk("R8 oe back", {35'd0, dout_oe}, 36'd1);

    // R12: reset hides the pending buffer
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 oe in reset", {35'd0, dout_oe}, 36'd0);
    rst_n = 1'b1; drv(1, 10'd5, 4'b1111);
    @(negedge clk); drv(0, 10'd0, 4'b1111);
    @(negedge clk);
    chk("R12 array after reset", dout, A5_ARRAY);
    chk("R12 oe", {35'd0, dout_oe}, 36'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule